// File: doc/BRIEF.md
# Shift-Register Video Timing Generator

This block produces horizontal sync, vertical sync, display-enable and start-of-line / start-of-frame markers for a raster display. It is clocked by the system clock and advances once per cycle in which a pixel-enable input is high. Position along a line and line within a frame are not held in binary counters. Each axis uses a 16-bit maximal-length shift register with feedback, which keeps the logic between flops to a single XOR level. A position's "count" is the number of steps taken since the register was last reloaded to all ones.

Because a shift-register state carries no order, every timing point is programmed as the register state reached after the desired number of steps, not as a binary count. Host software converts its binary timings into these states. The block compares the live position against these states. Each window (sync or active area) is a flag that sets on a start match and clears on an end match or at the axis wrap. A disable input parks both axes at their reload state and holds every output low. When disable is released, the raster restarts at the first pixel of the first line.

Top module: `lfsr_video_timing`

## Requirements
- R1: While reset is active, and until the block has armed, all five outputs are low. Arming takes one clock after reset is released with disable low.
- R2: Each step shifts the position register left by one bit. The new bit 0 is the XOR of the old bits 15, 4, 2 and 1, and a count of 0 is the state 0xFFFF. When the horizontal position equals the horizontal end compare (the state for count Nh), the next pixel enable reloads it to 0xFFFF, so a line lasts Nh+1 pixel enables.
- R3: The vertical position steps once per horizontal wrap. It reloads to 0xFFFF on the wrap that finds it equal to the vertical end compare (state for count Nv), so a frame lasts Nv+1 lines.
- R4: hsync is high for the horizontal counts from the sync-start state (inclusive) up to the sync-end state (exclusive). With start at count 1 and end at count W+1, the pulse lasts W pixels. If start and end are the same state, the end match wins.
- R5: vsync is high for the line counts from the vertical sync-start state (inclusive) up to the vertical sync-end state (exclusive). With start at count 0 and end at count W, the pulse lasts W lines.
- R6: de is high only when the horizontal count lies in [display start, display end) and the line count lies in its own vertical window. A window whose end state is never reached closes at the axis wrap.
- R7: line_start is high while the horizontal count is 0. frame_start is high while both the horizontal and the line count are 0.
- R8: A clock with pixel enable low changes no output and does not move either position.
- R9: One clock after disable is sampled high, all outputs are low and both positions sit at 0xFFFF. One clock after disable is sampled low again, line_start and frame_start are high and the raster runs from count 0 on both axes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-rate advance enable |
| disable_i | input | 1 | Parks both axes and forces outputs low |
| h_disp_start_i | input | 16 | Horizontal active-area start state |
| h_disp_end_i | input | 16 | Horizontal active-area end state |
| h_end_i | input | 16 | Horizontal last-count state |
| h_sync_start_i | input | 16 | hsync start state |
| h_sync_end_i | input | 16 | hsync end state |
| v_disp_start_i | input | 16 | Vertical active-area start state |
| v_disp_end_i | input | 16 | Vertical active-area end state |
| v_end_i | input | 16 | Vertical last-line state |
| v_sync_start_i | input | 16 | vsync start state |
| v_sync_end_i | input | 16 | vsync end state |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| line_start_o | output | 1 | High during count 0 of every line |
| frame_start_o | output | 1 | High during count 0 of line 0 |

## Verification
The bench builds the block with its default 16-bit width, 0xFFFF reload state and tap mask, so every compare state it programs comes from a behavioural software model of that exact register. It uses two small rasters, 20 by 10 and 16 by 7. These make many line and frame wraps, vertical window edges and a window end beyond the last count occur within a few thousand cycles. Runs at full pixel rate allow direct measurement of line length, frame length and hsync width. Runs with a sparse pixel enable and a mid-frame disable exercise holding and restart.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Window and marker flags carried by each axis
    typedef struct packed {
        logic sync;
        logic act;
        logic first;
    } vtg_flags_t;

    // Set/clear flag update: an end match beats a start match, and a wrap
    // closes any window still open.
    function automatic logic win_next(input logic cur, input logic at_start,
                                      input logic at_end, input logic wrap);
        logic r;
        if (at_end)        r = 1'b0;
        else if (at_start) r = 1'b1;
        else if (wrap)     r = 1'b0;
        else               r = cur;
        return r;
    endfunction

endpackage

// File: rtl/vtg_lfsr_step.sv
module vtg_lfsr_step #(
    parameter int unsigned POS_W = 16,
    parameter logic [POS_W-1:0] TAPS = 16'h8016
) (
    input  logic [POS_W-1:0] cur_i,
    output logic [POS_W-1:0] nxt_o
);
    logic fb;

    always_comb begin
        fb    = ^(cur_i & TAPS);
        nxt_o = {cur_i[POS_W-2:0], fb};
    end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int unsigned      POS_W = 16,
    parameter logic [POS_W-1:0] SEED  = 16'hFFFF,
    parameter logic [POS_W-1:0] TAPS  = 16'h8016
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             arm_i,
    input  logic             adv_i,
    input  logic [POS_W-1:0] disp_start_i,
    input  logic [POS_W-1:0] disp_end_i,
    input  logic [POS_W-1:0] sync_start_i,
    input  logic [POS_W-1:0] sync_end_i,
    input  logic [POS_W-1:0] end_i,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o,
    output vtg_flags_t       flags_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        vtg_flags_t       fl;
    } axis_st_t;

    axis_st_t         st_d, st_q;
    logic [POS_W-1:0] step_w;
    logic [POS_W-1:0] npos;
    logic             wrap_w;
    logic             eval_wrap;

    vtg_lfsr_step #(.POS_W(POS_W), .TAPS(TAPS)) u_step (
        .cur_i (st_q.pos),
        .nxt_o (step_w)
    );

    always_comb begin
        wrap_w    = adv_i && (st_q.pos == end_i);
        npos      = st_q.pos;
        eval_wrap = 1'b0;
        if (arm_i) begin
            npos      = SEED;
            eval_wrap = 1'b1;
        end else if (adv_i) begin
            npos      = wrap_w ? SEED : step_w;
            eval_wrap = wrap_w;
        end

        st_d = st_q;
        if (clear_i) begin
            st_d.pos = SEED;
            st_d.fl  = '0;
        end else if (arm_i || adv_i) begin
            st_d.pos      = npos;
            st_d.fl.sync  = win_next(st_q.fl.sync, npos == sync_start_i,
                                     npos == sync_end_i, eval_wrap);
            st_d.fl.act   = win_next(st_q.fl.act, npos == disp_start_i,
                                     npos == disp_end_i, eval_wrap);
            st_d.fl.first = (npos == SEED);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pos <= SEED;
            st_q.fl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o   = st_q.pos;
    assign wrap_o  = wrap_w;
    assign flags_o = st_q.fl;
endmodule

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing
    import vtg_pkg::*;
#(
    parameter int unsigned      POS_W = 16,
    parameter logic [POS_W-1:0] SEED  = 16'hFFFF,
    parameter logic [POS_W-1:0] TAPS  = 16'h8016
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pix_en_i,
    input  logic             disable_i,
    input  logic [POS_W-1:0] h_disp_start_i,
    input  logic [POS_W-1:0] h_disp_end_i,
    input  logic [POS_W-1:0] h_end_i,
    input  logic [POS_W-1:0] h_sync_start_i,
    input  logic [POS_W-1:0] h_sync_end_i,
    input  logic [POS_W-1:0] v_disp_start_i,
    input  logic [POS_W-1:0] v_disp_end_i,
    input  logic [POS_W-1:0] v_end_i,
    input  logic [POS_W-1:0] v_sync_start_i,
    input  logic [POS_W-1:0] v_sync_end_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             line_start_o,
    output logic             frame_start_o
);
    localparam int unsigned N_AX = 2;

    logic run_d, run_q;
    logic arm;

    logic [POS_W-1:0] ax_ds   [N_AX];
    logic [POS_W-1:0] ax_de   [N_AX];
    logic [POS_W-1:0] ax_ss   [N_AX];
    logic [POS_W-1:0] ax_se   [N_AX];
    logic [POS_W-1:0] ax_end  [N_AX];
    logic [POS_W-1:0] ax_pos  [N_AX];
    logic             ax_adv  [N_AX];
    logic             ax_wrap [N_AX];
    vtg_flags_t       ax_fl   [N_AX];

    always_comb begin
        run_d = !disable_i;
        arm   = !disable_i && !run_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= 1'b0;
        else         run_q <= run_d;
    end

    assign ax_ds[0]  = h_disp_start_i;
    assign ax_de[0]  = h_disp_end_i;
    assign ax_ss[0]  = h_sync_start_i;
    assign ax_se[0]  = h_sync_end_i;
    assign ax_end[0] = h_end_i;
    assign ax_ds[1]  = v_disp_start_i;
    assign ax_de[1]  = v_disp_end_i;
    assign ax_ss[1]  = v_sync_start_i;
    assign ax_se[1]  = v_sync_end_i;
    assign ax_end[1] = v_end_i;

    for (genvar g = 0; g < N_AX; g++) begin : g_axis
        if (g == 0) begin : g_src
            assign ax_adv[g] = run_q && !disable_i && pix_en_i;
        end else begin : g_chain
            assign ax_adv[g] = ax_adv[g-1] && ax_wrap[g-1];
        end

        vtg_axis #(.POS_W(POS_W), .SEED(SEED), .TAPS(TAPS)) u_axis (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .clear_i      (disable_i),
            .arm_i        (arm),
            .adv_i        (ax_adv[g]),
            .disp_start_i (ax_ds[g]),
            .disp_end_i   (ax_de[g]),
            .sync_start_i (ax_ss[g]),
            .sync_end_i   (ax_se[g]),
            .end_i        (ax_end[g]),
            .pos_o        (ax_pos[g]),
            .wrap_o       (ax_wrap[g]),
            .flags_o      (ax_fl[g])
        );
    end

    assign hsync_o       = ax_fl[0].sync;
    assign vsync_o       = ax_fl[1].sync;
    assign de_o          = ax_fl[0].act && ax_fl[1].act;
    assign line_start_o  = ax_fl[0].first;
    assign frame_start_o = ax_fl[0].first && ax_fl[1].first;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int unsigned      POS_W = 16,
    parameter logic [POS_W-1:0] SEED  = 16'hFFFF
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pix_en_i,
    input logic             disable_i,
    input logic             run_q,
    input logic             h_adv,
    input logic             v_wrap,
    input logic [POS_W-1:0] h_pos,
    input logic [POS_W-1:0] h_end_i,
    input logic [POS_W-1:0] h_sync_start_i,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             de_o,
    input logic             line_start_o,
    input logic             frame_start_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> (!hsync_o && !vsync_o && !de_o && !line_start_o));

    // R2
    line_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (h_adv && h_pos == h_end_i) |=> (h_pos == SEED && line_start_o));

    // R3
    frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_wrap |=> frame_start_o);

    // R4
    hsync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $rose(hsync_o)) |-> (h_pos == h_sync_start_i));

    // R8
    pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !disable_i && !pix_en_i) |=>
        ($stable(hsync_o) && $stable(vsync_o) && $stable(de_o)
         && $stable(line_start_o) && $stable(h_pos)));

    // R9
    park_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disable_i |=> (!hsync_o && !vsync_o && !de_o && !frame_start_o && h_pos == SEED));

    // R9
    restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!disable_i && !run_q) |=> (line_start_o && frame_start_o));
endmodule

bind lfsr_video_timing vtg_checker #(.POS_W(POS_W), .SEED(SEED)) u_vtg_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pix_en_i       (pix_en_i),
    .disable_i      (disable_i),
    .run_q          (run_q),
    .h_adv          (ax_adv[0]),
    .v_wrap         (ax_wrap[1]),
    .h_pos          (ax_pos[0]),
    .h_end_i        (h_end_i),
    .h_sync_start_i (h_sync_start_i),
    .hsync_o        (hsync_o),
    .vsync_o        (vsync_o),
    .de_o           (de_o),
    .line_start_o   (line_start_o),
    .frame_start_o  (frame_start_o)
);

// File: tb/test_lfsr_video_timing.sv
`timescale 1ns/1ps
module test_lfsr_video_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        dis = 1'b0;
    logic [15:0] hds, hde, hend, hss, hse, vds, vde, vend, vss, vse;
    logic        hs, vs, de, ls, fs;

    always #5 clk = ~clk;

    lfsr_video_timing i_lfsr_video_timing (
        .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .disable_i(dis),
        .h_disp_start_i(hds), .h_disp_end_i(hde), .h_end_i(hend),
        .h_sync_start_i(hss), .h_sync_end_i(hse),
        .v_disp_start_i(vds), .v_disp_end_i(vde), .v_end_i(vend),
        .v_sync_start_i(vss), .v_sync_end_i(vse),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .line_start_o(ls), .frame_start_o(fs));

    // binary timing of the current raster
    int c_htot, c_hsw, c_hds, c_hde, c_vlines, c_vsw, c_vds, c_vde;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // software model of the position register: state after n steps
    function automatic logic [15:0] state_after(input int n);
        logic [15:0] s = 16'hFFFF;
        for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
        return s;
    endfunction

    task automatic program_raster(input int htot, input int hsw, input int hd0, input int hd1,
                                  input int vl, input int vsw, input int vd0, input int vd1);
        c_htot = htot; c_hsw = hsw; c_hds = hd0; c_hde = hd1;
        c_vlines = vl; c_vsw = vsw; c_vds = vd0; c_vde = vd1;
        hend = state_after(htot - 1);
        hss  = state_after(1);
        hse  = state_after(hsw + 1);
        hds  = state_after(hd0);
        hde  = state_after(hd1);
        vend = state_after(vl - 1);
        vss  = state_after(0);
        vse  = state_after(vsw);
        vds  = state_after(vd0);
        vde  = state_after(vd1);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    bit m_run = 0;
    int m_h = 0, m_v = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run <= 0; m_h <= 0; m_v <= 0;
        end else if (dis) begin
            m_run <= 0; m_h <= 0; m_v <= 0;
        end else if (!m_run) begin
            m_run <= 1; m_h <= 0; m_v <= 0;
        end else if (pix_en) begin
            if (m_h == c_htot - 1) begin
                m_h <= 0;
                m_v <= (m_v == c_vlines - 1) ? 0 : m_v + 1;
            end else begin
                m_h <= m_h + 1;
            end
        end
    end

    // per-cycle compare and measurements, away from the active edge
    bit meas_on = 0;
    int cyc = 0, last_ls = -1, last_fs = -1, hs_len = 0;
    logic p_ls = 0, p_fs = 0, p_hs = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            chk("R1 reset hsync", hs, 0);
            chk("R1 reset vsync", vs, 0);
            chk("R1 reset de", de, 0);
            chk("R1 reset line_start", ls, 0);
        end else if (!done) begin
            chk("R4 hsync", hs, m_run && m_h >= 1 && m_h < c_hsw + 1);
            chk("R5 vsync", vs, m_run && m_v < c_vsw);
            chk("R6 de", de, m_run && m_h >= c_hds && m_h < c_hde && m_v >= c_vds && m_v < c_vde);
            chk("R7 line_start", ls, m_run && m_h == 0);
            chk("R7 frame_start", fs, m_run && m_h == 0 && m_v == 0);
            if (!meas_on) begin
                last_ls = -1; last_fs = -1; hs_len = 0;
            end else begin
                if (ls && !p_ls) begin
                    if (last_ls >= 0) chk("R2 measured line length", cyc - last_ls, c_htot);
                    last_ls = cyc;
                end
                if (fs && !p_fs) begin
                    if (last_fs >= 0) chk("R3 measured frame length", cyc - last_fs, c_htot * c_vlines);
                    last_fs = cyc;
                end
                if (hs) hs_len++;
                if (!hs && p_hs) begin
                    chk("R4 measured hsync width", hs_len, c_hsw);
                    hs_len = 0;
                end
            end
        end
        p_ls = ls; p_fs = fs; p_hs = hs;
    end

    task automatic run_cycles(input int n, input bit sparse);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            pix_en = sparse ? (i % 3 != 2) : 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        program_raster(20, 3, 6, 18, 10, 2, 3, 8);
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: still quiet on the arming cycle is covered by the per-cycle compare
        meas_on = 1;
        run_cycles(450, 0);                 // R2 R3 R4 full-rate frames
        meas_on = 0;
        run_cycles(700, 1);                 // R8 sparse pixel enable
        @(negedge clk); #1 dis = 1'b1;      // R9 park mid-frame
        run_cycles(4, 0);
        @(negedge clk); #1 dis = 1'b0;
        @(negedge clk); #1;
        chk("R9 restart line_start", ls, 1);
        chk("R9 restart frame_start", fs, 1);
        meas_on = 1;
        run_cycles(260, 0);
        meas_on = 0;
        @(negedge clk); #1 dis = 1'b1;
        @(negedge clk); #1;
        program_raster(16, 2, 5, 16, 7, 3, 4, 7);   // R6 window ends past the last count
        @(negedge clk); #1 dis = 1'b0;
        meas_on = 1;
        run_cycles(300, 0);
        meas_on = 0;
        run_cycles(300, 1);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end
endmodule